// File: doc/BRIEF.md
# Rounding Saturating Narrowing Shifter

This unit is a vector datapath stage. It splits a wide source vector into signed 16-bit lanes. For each lane it adds a rounding constant of half the shift step and shifts the sum right arithmetically by an immediate amount. It then clamps the result into the unsigned byte range. Each narrowed byte is placed in the upper byte of its own 16-bit slot. The lower byte of every slot is copied from a prior destination vector, so two narrowing passes can fill one destination in an interleaved way.

The operation is presented with a one-cycle strobe. The result is registered and appears one clock later together with a valid flag. An immediate outside the range 1 to 8 performs no narrowing: the prior destination is returned unchanged and an error flag is raised alongside the result. The vector width is a parameter and may be any of 128, 256, 512, 1024 or 2048 bits.

Top module: `narrow_shift_unit`

## Requirements
- R1: For each lane with signed value x and shift amount s in 1..8, the pre-clamp value is floor((x + 2^(s-1)) / 2^s). The sum is formed in at least 17 signed bits, so it never wraps.
- R2: Rounding is half-up: the result is one more than the plain arithmetic shift exactly when the highest bit shifted out is 1.
- R3: A negative pre-clamp value produces the byte 0x00. Any negative source lane therefore yields 0x00.
- R4: A pre-clamp value above 255 produces 0xFF. A source of 0x7FFF with s=1 yields 0xFF.
- R5: The byte produced for lane k appears on out_vec bits [16k+15:16k+8].
- R6: Bits [16k+7:16k] of out_vec equal the same bits of dst_prev sampled with the strobe.
- R7: When the strobe is high and shamt is 0 or greater than 8, out_vec becomes dst_prev unchanged and out_err is 1. For a valid shamt, out_err is 0.
- R8: out_valid equals in_valid delayed by one clock, and each result appears in that same cycle.
- R9: Synchronous reset clears out_valid, out_err and out_vec to zero.
- R10: While in_valid is low, out_vec holds its value and out_err is 0.
- R11: The lane count follows the VLEN parameter (VLEN/16 lanes). A 256-bit instance narrows all 16 lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | VLEN | Source vector of signed 16-bit lanes |
| dst_prev | input | VLEN | Prior destination value; its even bytes pass through |
| shamt | input | 4 | Right shift amount, legal range 1..8 |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_vec | output | VLEN | Registered merged result |
| out_err | output | 1 | Illegal shift amount seen with this result |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- even-byte pass-through in every lane;
- the unchanged return and error flag for illegal shift amounts;
- zero output for negative lanes;
- holding of the result while idle.

The exact rounded and clamped byte values can only be shown by the bench's scenarios. These cover the ties at the rounding point, the saturation edges at 255/256, the most positive and most negative sources at the largest and smallest shift, and a second instance at a wider vector length.

// File: rtl/nsu_pkg.sv
package nsu_pkg;
  localparam int LANE_W = 16;
  localparam int BYTE_W = 8;
  localparam int SH_W   = 4;
  localparam int SH_MAX = 8;
  localparam int SUM_W  = LANE_W + 1;
endpackage

// File: rtl/nsu_shamt_check.sv
module nsu_shamt_check
  import nsu_pkg::*;
(
  input  logic [SH_W-1:0] shamt,
  output logic            bad
);
  always_comb begin
    bad = (shamt == '0) || (shamt > SH_W'(SH_MAX));
  end
endmodule

// File: rtl/nsu_lane.sv
module nsu_lane
  import nsu_pkg::*;
(
  input  logic [LANE_W-1:0] src,
  input  logic [SH_W-1:0]   shamt,
  output logic [BYTE_W-1:0] res
);
  logic signed [SUM_W-1:0] ext;
  logic signed [SUM_W-1:0] rnd;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] shd;

  always_comb begin
    ext = {src[LANE_W-1], src};
    if (shamt == '0) rnd = '0;
    else             rnd = {{(SUM_W-1){1'b0}}, 1'b1} << (shamt - SH_W'(1));
    sum = ext + rnd;
    shd = sum >>> shamt;
    if (shd[SUM_W-1])                res = '0;
    else if (|shd[SUM_W-2:BYTE_W])   res = '1;
    else                             res = shd[BYTE_W-1:0];
  end
endmodule

// File: rtl/narrow_shift_unit.sv
module narrow_shift_unit
  import nsu_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] dst_prev,
  input  logic [SH_W-1:0] shamt,
  output logic            out_valid,
  output logic [VLEN-1:0] out_vec,
  output logic            out_err
);
  localparam int LANES = VLEN / LANE_W;

  logic            bad_sh;
  logic [VLEN-1:0] merged;

  nsu_shamt_check u_chk (.shamt(shamt), .bad(bad_sh));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BYTE_W-1:0] nb;
    nsu_lane u_lane (
      .src  (src_vec[k*LANE_W +: LANE_W]),
      .shamt(shamt),
      .res  (nb)
    );
    assign merged[k*LANE_W +: BYTE_W]          = dst_prev[k*LANE_W +: BYTE_W];
    assign merged[k*LANE_W + BYTE_W +: BYTE_W] = nb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & bad_sh;
      if (in_valid) out_vec <= bad_sh ? dst_prev : merged;
    end
  end
endmodule

// File: rtl/narrow_shift_unit_chk.sv
module narrow_shift_unit_chk
  import nsu_pkg::*;
#(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [VLEN-1:0] src_vec,
  input logic [VLEN-1:0] dst_prev,
  input logic [SH_W-1:0] shamt,
  input logic            out_valid,
  input logic [VLEN-1:0] out_vec,
  input logic            out_err
);
  localparam int LANES = VLEN / LANE_W;

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7
  bad_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (shamt == '0 || shamt > SH_W'(SH_MAX)))
      |=> (out_err && out_vec == $past(dst_prev)));
  // R7
  good_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt != '0 && shamt <= SH_W'(SH_MAX)) |=> !out_err);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_vec) && !out_err));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R6
    even_keep_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_vec[k*LANE_W +: BYTE_W] == $past(dst_prev[k*LANE_W +: BYTE_W]));
    // R3
    neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && src_vec[k*LANE_W + LANE_W - 1] && shamt != '0 && shamt <= SH_W'(SH_MAX))
        |=> out_vec[k*LANE_W + BYTE_W +: BYTE_W] == '0);
  end
endmodule

bind narrow_shift_unit narrow_shift_unit_chk #(.VLEN(VLEN)) u_nsu_chk (.*);

// File: tb/test_narrow_shift_unit.sv
module test_narrow_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN  = 128;
  localparam int LANES = VLEN / 16;
  localparam int WLEN  = 256;
  localparam int NTV   = 15;

  // x, shift, expected byte (R1 R2 R3 R4)
  localparam logic [15:0] TV_X  [NTV] = '{16'h7FFF, 16'hFFFF, 16'hFFFE, 16'h01FF, 16'h01FC,
                                          16'h0180, 16'h017F, 16'h007F, 16'h0080, 16'h8000,
                                          16'h000A, 16'h0009, 16'h7FFF, 16'h7FFF, 16'h7F80};
  localparam logic [3:0]  TV_SH [NTV] = '{4'd1, 4'd1, 4'd1, 4'd1, 4'd1,
                                          4'd8, 4'd8, 4'd8, 4'd8, 4'd8,
                                          4'd2, 4'd2, 4'd8, 4'd7, 4'd8};
  localparam logic [7:0]  TV_E  [NTV] = '{8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFE,
                                          8'h02, 8'h01, 8'h00, 8'h01, 8'h00,
                                          8'h03, 8'h02, 8'h80, 8'hFF, 8'h80};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [VLEN-1:0] src_vec = '0;
  logic [VLEN-1:0] dst_prev = '0;
  logic [3:0] shamt = 4'd1;
  logic out_valid, out_err;
  logic [VLEN-1:0] out_vec;

  logic w_valid = 1'b0;
  logic [WLEN-1:0] w_src = '0;
  logic [WLEN-1:0] w_dst = '0;
  logic w_ovalid, w_err;
  logic [WLEN-1:0] w_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  narrow_shift_unit #(.VLEN(VLEN)) i_narrow_shift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec), .dst_prev(dst_prev),
    .shamt(shamt), .out_valid(out_valid), .out_vec(out_vec), .out_err(out_err));

  narrow_shift_unit #(.VLEN(WLEN)) i_narrow_shift_unit_wide (
    .clk(clk), .rst(rst), .in_valid(w_valid), .src_vec(w_src), .dst_prev(w_dst),
    .shamt(shamt), .out_valid(w_ovalid), .out_vec(w_out), .out_err(w_err));

  function automatic logic [7:0] ref_narrow(logic [15:0] x, int sh);
    int v;
    v = $signed(x);
    v = (v + (1 <<< (sh - 1))) >>> sh;
    if (v < 0) return 8'h00;
    if (v > 255) return 8'hFF;
    return v[7:0];
  endfunction

  task automatic check(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic apply(input logic [VLEN-1:0] s, input logic [VLEN-1:0] d, input logic [3:0] sh);
    @(negedge clk);
    src_vec = s; dst_prev = d; shamt = sh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [VLEN-1:0] d, s, e;
    repeat (3) @(negedge clk);
    // R9 reset state
    check_bit("R9 valid", out_valid, 1'b0);
    check_bit("R9 err", out_err, 1'b0);
    check("R9 vec", out_vec, '0);
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < LANES; k++) begin
      d[k*16 +: 16] = {8'(8'hC0 + k), 8'(8'h10 + k)};
    end

    // Table walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NTV; i++) begin
      for (int k = 0; k < LANES; k++) begin
        s[k*16 +: 16] = TV_X[i];
        e[k*16 +: 16] = {TV_E[i], 8'(8'h10 + k)};
      end
      apply(s, d, TV_SH[i]);
      check("R1/R2/R3/R4/R5/R6 table", out_vec, e);
      check_bit("R8 valid", out_valid, 1'b1);
      check_bit("R7 no err", out_err, 1'b0);
    end

    // Mixed lanes, shift 3: R5 per-lane placement
    for (int k = 0; k < LANES; k++) begin
      s[k*16 +: 16] = 16'(k * 1000 - 2500);
      e[k*16 +: 16] = {ref_narrow(16'(k * 1000 - 2500), 3), 8'(8'h10 + k)};
    end
    apply(s, d, 4'd3);
    check("R5 mixed lanes", out_vec, e);

    // R10 hold while idle, with changed inputs
    @(negedge clk);
    src_vec = ~src_vec; dst_prev = ~dst_prev; shamt = 4'd0;
    @(negedge clk);
    check("R10 hold", out_vec, e);
    check_bit("R10 err low", out_err, 1'b0);
    check_bit("R8 idle valid", out_valid, 1'b0);

    // R7 illegal shifts
    apply(s, d, 4'd0);
    check("R7 sh0 unchanged", out_vec, d);
    check_bit("R7 sh0 err", out_err, 1'b1);
    apply(s, ~d, 4'd9);
    check("R7 sh9 unchanged", out_vec, ~d);
    check_bit("R7 sh9 err", out_err, 1'b1);
    apply(s, d, 4'd15);
    check("R7 sh15 unchanged", out_vec, d);
    check_bit("R7 sh15 err", out_err, 1'b1);

    // R11 wide instance
    begin
      logic [WLEN-1:0] we;
      @(negedge clk);
      for (int k = 0; k < WLEN/16; k++) begin
        w_src[k*16 +: 16] = 16'(k * 37);
        w_dst[k*16 +: 16] = {8'hAA, 8'(k)};
        we[k*16 +: 16] = {ref_narrow(16'(k * 37), 1), 8'(k)};
      end
      shamt = 4'd1; w_valid = 1'b1;
      @(negedge clk);
      w_valid = 1'b0;
      checks++;
      if (w_out !== we || w_ovalid !== 1'b1) begin
        errors++;
        $display("FAIL R11 wide: actual=%h expected=%h", w_out, we);
      end
    end

    // R9 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9 re-reset vec", out_vec, '0);
    check_bit("R9 re-reset valid", out_valid, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule